// File: doc/BRIEF.md
# Serial DAC Word Loader with Alarm Detection

This block is the digital front end of a 16-bit current-loop DAC. A host drives three slow asynchronous wires: a serial data line, a serial bit clock and a load strobe. The block samples all three with a fast system clock and detects their rising edges. On each rising edge of the bit clock it shifts the data bit into a 16-bit word, most significant bit first. It also counts how many bit-clock edges arrive since the last load strobe.

On a rising edge of the load strobe the block judges the word by that edge count. Exactly 16 edges is an ordinary loop-current word, and the code is latched with the alarm flag low. More than 16 edges is an out-of-range alarm request: the last 16 bits shifted are latched and the alarm flag goes high. Fewer than 16 edges is a broken transfer. The latched code and flag keep their values and an error strobe pulses instead. The latched code is straight binary, from 0 (4 mA zero scale) up to all ones (20 mA full scale). It drives the downstream modulator, which is outside this block.

Top module: `dacl_serial_loader`

## Requirements
- R1: Each rising edge of `sclk_in` shifts the value of `data_in` into the word register, most significant bit first, so that after 16 edges the first bit sent sits at bit 15 and the last at bit 0.
- R2: A rising edge of `ld_in` preceded by at least 16 clock edges copies the word register to `dac_code` and raises `update_stb` for exactly one system clock cycle.
- R3: `dac_code` and `alarm_mode` change only in a cycle where `update_stb` is high.
- R4: A load preceded by exactly 16 clock edges drives `alarm_mode` to 0 (normal current data).
- R5: A load preceded by more than 16 clock edges drives `alarm_mode` to 1 and latches the last 16 bits shifted in before the load edge.
- R6: The edge counter saturates at 17 however long the burst is, and it clears to zero after every load edge, so a load after a long burst still reads as alarm and the next 16-edge word reads as normal.
- R7: A load preceded by fewer than 16 clock edges, including none, leaves `dac_code` and `alarm_mode` unchanged, raises `error_stb` for one cycle and does not raise `update_stb`.
- R8: Synchronous reset sets `dac_code` to 0 and `alarm_mode` to 0, holds both strobes low and clears the partly received word and its edge count.
- R9: `update_stb` and `error_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Asynchronous serial data line |
| sclk_in | input | 1 | Asynchronous serial bit clock |
| ld_in | input | 1 | Asynchronous load strobe, acts on its rising edge |
| dac_code | output | 16 | Latched binary DAC code |
| alarm_mode | output | 1 | 1 = alarm-current word, 0 = normal loop-current word |
| update_stb | output | 1 | One-cycle pulse when a new code is latched |
| error_stb | output | 1 | One-cycle pulse when a short transfer is discarded |

## Verification
The embedded assertions check on every cycle that the edge counter never exceeds its saturation value and returns to zero after a load. They also check that the outputs move only together with the update strobe, that an error strobe leaves them untouched, and that the alarm flag matches the edge count seen at the load edge. The bench scenarios are needed to show the data side: that bit order is most significant first, which 16 bits survive an overlong burst, that full-scale and zero codes pass intact, and that a reset in the middle of a word discards the partial count.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
  typedef enum logic [1:0] {
    VERD_SHORT  = 2'd0,
    VERD_NORMAL = 2'd1,
    VERD_ALARM  = 2'd2
  } verdict_e;
endpackage

// File: rtl/dacl_sync.sv
module dacl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], async_i[b]};
        prev  <= chain[STAGES-1];
      end
    end
    assign sync_o[b] = chain[STAGES-1];
    assign rise_o[b] = chain[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/dacl_shifter.sv
module dacl_shifter
  import dacl_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SAT   = WORD_W + 1,
  localparam int CNT_W = $clog2(SAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_i,
  input  logic              edge_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output verdict_e          verdict_o
);
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
    end else if (edge_i) begin
      word_q <= {word_q[WORD_W-2:0], bit_i};
      if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q > CNT_W'(WORD_W))       verdict_o = VERD_ALARM;
    else if (cnt_q == CNT_W'(WORD_W)) verdict_o = VERD_NORMAL;
    else                              verdict_o = VERD_SHORT;
  end

  assign word_o = word_q;
  assign cnt_o  = cnt_q;

  assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(SAT));
  assert_cnt_clears_R6: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == '0);
endmodule

// File: rtl/dacl_outreg.sv
module dacl_outreg
  import dacl_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  verdict_e          verdict_i,
  output logic [WORD_W-1:0] code_o,
  output logic              alarm_o,
  output logic              upd_o,
  output logic              err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_o  <= '0;
      alarm_o <= 1'b0;
      upd_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      err_o <= 1'b0;
      if (load_i) begin
        if (verdict_i == VERD_SHORT) begin
          err_o <= 1'b1;
        end else begin
          code_o  <= word_i;
          alarm_o <= (verdict_i == VERD_ALARM);
          upd_o   <= 1'b1;
        end
      end
    end
  end

  assert_quiet_outputs_R3: assert property (@(posedge clk) disable iff (rst)
    !upd_o |-> ($stable(code_o) && $stable(alarm_o)));
  assert_error_holds_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($stable(code_o) && $stable(alarm_o) && !upd_o));
  assert_alarm_matches_count_R5: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (($past(cnt_i) >= CNT_W'(WORD_W)) &&
               (alarm_o == ($past(cnt_i) > CNT_W'(WORD_W)))));
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);
  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({upd_o, err_o}));
endmodule

// File: rtl/dacl_serial_loader.sv
module dacl_serial_loader
  import dacl_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_in,
  input  logic              sclk_in,
  input  logic              ld_in,
  output logic [WORD_W-1:0] dac_code,
  output logic              alarm_mode,
  output logic              update_stb,
  output logic              error_stb
);
  localparam int PIN_DATA = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_LD   = 2;

  logic [2:0]        pins_sync;
  logic [2:0]        pins_rise;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;
  verdict_e          verdict;

  dacl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ld_in, sclk_in, data_in}),
    .sync_o  (pins_sync),
    .rise_o  (pins_rise)
  );

  dacl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_i     (pins_sync[PIN_DATA]),
    .edge_i    (pins_rise[PIN_SCLK]),
    .load_i    (pins_rise[PIN_LD]),
    .word_o    (word),
    .cnt_o     (cnt),
    .verdict_o (verdict)
  );

  dacl_outreg #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load_i    (pins_rise[PIN_LD]),
    .word_i    (word),
    .cnt_i     (cnt),
    .verdict_i (verdict),
    .code_o    (dac_code),
    .alarm_o   (alarm_mode),
    .upd_o     (update_stb),
    .err_o     (error_stb)
  );
endmodule

// File: tb/dacl_serial_loader_tb.sv
module dacl_serial_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        data_in = 1'b0;
  logic        sclk_in = 1'b0;
  logic        ld_in = 1'b0;
  logic [15:0] dac_code;
  logic        alarm_mode, update_stb, error_stb;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct packed {
    logic        err;
    logic        alarm;
    logic [15:0] code;
  } exp_t;
  exp_t        expq[$];
  logic [15:0] mdl_code = '0;
  logic        mdl_alarm = 1'b0;
  logic [15:0] cur_code = '0;
  logic        cur_alarm = 1'b0;

  localparam int PH = 5;

  always #5 clk = ~clk;

  dacl_serial_loader u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .sclk_in(sclk_in), .ld_in(ld_in),
    .dac_code(dac_code), .alarm_mode(alarm_mode),
    .update_stb(update_stb), .error_stb(error_stb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: send nbits of vec (MSB first) then a load pulse; push expectation.
  task automatic load_word(input logic [63:0] vec, input int nbits, input string req);
    exp_t e;
    if (nbits < 16) begin
      e.err = 1'b1; e.alarm = mdl_alarm; e.code = mdl_code;
    end else begin
      e.err = 1'b0; e.alarm = (nbits > 16); e.code = vec[15:0];
      mdl_code = vec[15:0]; mdl_alarm = (nbits > 16);
    end
    expq.push_back(e);
    for (int i = nbits - 1; i >= 0; i--) begin
      data_in = vec[i];
      wait_clk(PH);
      sclk_in = 1'b1;
      wait_clk(PH);
      sclk_in = 1'b0;
    end
    wait_clk(PH);
    ld_in = 1'b1;
    wait_clk(PH);
    ld_in = 1'b0;
    wait_clk(PH + 4);
    check(expq.size() == 0, req, "transfer result not observed", expq.size(), 0);
  endtask

  task automatic do_reset();
    wait_clk(1);
    rst = 1'b1;
    data_in = 1'b0; sclk_in = 1'b0; ld_in = 1'b0;
    mdl_code = '0; mdl_alarm = 1'b0;
    cur_code = '0; cur_alarm = 1'b0;
    wait_clk(4);
    check(dac_code == 16'h0, "R8", "reset code", dac_code, 0);
    check(alarm_mode == 1'b0, "R8", "reset alarm", alarm_mode, 0);
    check(!update_stb && !error_stb, "R8", "reset strobes",
          {update_stb, error_stb}, 0);
    rst = 1'b0;
    wait_clk(2);
  endtask

  // Monitor: pop an expectation on each strobe; otherwise outputs must hold.
  always @(negedge clk) begin
    if (!rst) begin
      if (update_stb && error_stb) begin
        check(1'b0, "R9", "both strobes high", 2'b11, 2'b00);
      end else if (update_stb || error_stb) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2", "unexpected strobe", {update_stb, error_stb}, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.err) begin
            check(error_stb, "R7", "short load strobe", {update_stb, error_stb}, 2'b01);
          end else begin
            check(update_stb, "R2", "update strobe", {update_stb, error_stb}, 2'b10);
            check(alarm_mode == e.alarm, e.alarm ? "R5" : "R4", "mode flag",
                  alarm_mode, e.alarm);
          end
          check(dac_code == e.code, "R1", "latched code", dac_code, e.code);
          check(!e.err || (alarm_mode == cur_alarm && dac_code == cur_code), "R7",
                "state held on short load", {alarm_mode, dac_code},
                {cur_alarm, cur_code});
          cur_code = e.code; cur_alarm = e.alarm;
        end
      end else if (dac_code != cur_code || alarm_mode != cur_alarm) begin
        check(1'b0, "R3", "output moved without strobe", {alarm_mode, dac_code},
              {cur_alarm, cur_code});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();                                   // R8
    load_word(64'h1234, 16, "R1");                // R1 R2 R4
    load_word(64'hFFFF, 16, "R4");                // full scale
    load_word(64'h0000, 16, "R4");                // zero scale
    load_word(64'hABCDE, 20, "R5");               // alarm, keeps 0xBCDE
    load_word(64'h1C3A5, 17, "R5");               // just over: 0xC3A5
    load_word(64'hDEAD_BEEF_0123_4567, 40, "R6"); // saturation, keeps 0x4567
    load_word(64'h5A5A, 16, "R6");                // counter cleared: normal
    load_word(64'h3FF, 10, "R7");                 // short: discarded
    load_word(64'h0, 0, "R7");                    // no edges: discarded
    load_word(64'h2_8001, 18, "R5");              // alarm 0x8001
    load_word(64'h7F, 15, "R7");                  // short while in alarm
    // R8: reset in the middle of a word drops the partial count
    for (int i = 0; i < 10; i++) begin
      data_in = i[0];
      wait_clk(PH); sclk_in = 1'b1; wait_clk(PH); sclk_in = 1'b0;
    end
    do_reset();
    load_word(64'hC0DE, 16, "R8");
    check(alarm_mode == 1'b0, "R8", "normal after mid-word reset", alarm_mode, 0);
    check(dac_code == 16'hC0DE, "R1", "code after mid-word reset", dac_code, 16'hC0DE);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule